// File: doc/BRIEF.md
# Chassis Slot Control Registers

This register block sits on a supervisor card and gives software a view of the line-card slots in a modular chassis. Software first writes a selector word that names one slot and one sub-function. It then reads a status register, and the value it gets back depends on that sub-function. The status can report whether a card is in the slot, whether the slot has power, whether the power converter is healthy, or the data-out bit of the slot's serial configuration memory. A fixed identification register tells software which slot the supervisor itself occupies.

A selector write with the power-on sub-function does more than select: it also sets a per-slot powered flag, and that flag stays set until reset. The supervisor's own slot always reports power good. Card presence comes in as one bit per slot. The serial memory's data-out bit and its "device selected" qualifier are driven from outside the block.

The bus has a write port and a read port that can both be active in the same cycle. Read data is registered and appears one cycle after the request.

Top module: `slot_ctl_regs`

## Requirements
- R1: A write to the selector offset 0x08 stores the whole data word, and a read of 0x08 returns it. The slot number is bits 15:12 of the stored word and the sub-function code is bits 11:8. `sel_slot_o` shows the stored slot number one cycle after the write.
- R2: Slot numbers count from 1: slot N owns bit N-1 of `powered_o`. A selector write with code 2 and slot N between 1 and NUM_SLOTS sets bit N-1. Other codes, slot 0 and slots above NUM_SLOTS change no bit. Only reset clears a bit.
- R3: A status read (offset 0x0C) with code 0 returns 0x1 when the selected slot is empty. When a card is present it returns bit 0 = 0 and bit 1 = power good. A slot number outside 1..NUM_SLOTS reads as empty.
- R4: Power good is 1 when the slot's powered flag is set or when the slot number equals `sup_slot_i`, whether or not the slot was ever powered by a write.
- R5: A status read with code 1 returns 0x1 for an empty slot and 0x0 for a present card.
- R6: A status read with code 2 returns 0x8, the converter-healthy bit (bit 3).
- R7: A status read with code 5 returns `eep_dout_i` in bit 0 while `eep_sel_i` is 1, and returns 0 while it is 0.
- R8: A status read with any other code returns 0 and sets `func_err_o`. The flag stays set until reset.
- R9: Offset 0x00 reads as `(sup_slot_i << 8) | 0x80`.
- R10: Offsets 0x10, 0x14 and 0x18 read as 0, and offset 0x1C reads as 0x8000. Any other offset reads as all ones. Writes to offsets other than 0x08 change nothing.
- R11: Read data and `rvalid_o` appear in the cycle after `rd_en`, and `rvalid_o` is 0 in the cycle after a cycle with no read. When a write and a read fall in the same cycle, the read uses the selector value from before the write.
- R12: Reset clears the selector, every powered flag, `func_err_o`, `rdata_o` and `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wdata | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rdata_o | output | DATA_W | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en |
| present_i | input | NUM_SLOTS | Card present, bit N-1 for slot N |
| sup_slot_i | input | 4 | Slot number of the supervisor |
| eep_sel_i | input | 1 | Serial memory of the selected slot is selected |
| eep_dout_i | input | 1 | Data-out bit of that serial memory |
| powered_o | output | NUM_SLOTS | Powered flags, bit N-1 for slot N |
| sel_slot_o | output | 4 | Currently selected slot number |
| func_err_o | output | 1 | Sticky flag for an unknown sub-function read |

## Verification
A selector write and a status read can fall in the same clock cycle, and that cycle decides which slot and code the read answers. The bench drives both strobes in one cycle. In one case the write moves the selection to an empty slot. In the other the write powers a different slot. Each time, the bench checks that the returned value belongs to the previous selection, and that the next ordinary read reflects the new one, including the newly set powered flag.

// File: rtl/slot_ctl_pkg.sv
package slot_ctl_pkg;
   localparam int SLOT_W = 4;
   localparam int FUNC_W = 4;

   typedef enum logic [FUNC_W-1:0] {
      FN_PRESENCE = 4'd0,
      FN_EMPTY    = 4'd1,
      FN_POWER    = 4'd2,
      FN_EEPROM   = 4'd5
   } slot_fn_e;

   localparam logic [7:0] OFF_ID   = 8'h00;
   localparam logic [7:0] OFF_SEL  = 8'h08;
   localparam logic [7:0] OFF_STAT = 8'h0C;
   localparam logic [7:0] OFF_RSV0 = 8'h10;
   localparam logic [7:0] OFF_RSV1 = 8'h14;
   localparam logic [7:0] OFF_RSV2 = 8'h18;
   localparam logic [7:0] OFF_MARK = 8'h1C;

   localparam logic [15:0] MARK_VAL = 16'h8000;
   localparam logic [7:0]  ID_LOW   = 8'h80;

   localparam int SLOT_LSB  = 12;
   localparam int FUNC_LSB  = 8;
   localparam int ST_EMPTY  = 0;
   localparam int ST_PGOOD  = 1;
   localparam int ST_CONV   = 3;
endpackage

// File: rtl/slot_sel_reg.sv
module slot_sel_reg
   import slot_ctl_pkg::*;
#(
   parameter int NUM_SLOTS = 9,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_we,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    sel_word,
   output logic [SLOT_W-1:0]    sel_slot,
   output logic [FUNC_W-1:0]    sel_fn,
   output logic [NUM_SLOTS-1:0] powered
);
   logic [SLOT_W-1:0] wr_slot;
   logic [FUNC_W-1:0] wr_fn;

   assign wr_slot  = wdata[SLOT_LSB +: SLOT_W];
   assign wr_fn    = wdata[FUNC_LSB +: FUNC_W];
   assign sel_slot = sel_word[SLOT_LSB +: SLOT_W];
   assign sel_fn   = sel_word[FUNC_LSB +: FUNC_W];

   always_ff @(posedge clk) begin
      if (!rst_n)      sel_word <= '0;
      else if (sel_we) sel_word <= wdata;
   end

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pwr
      localparam logic [SLOT_W-1:0] SLOT_NUM = SLOT_W'(i + 1);
      always_ff @(posedge clk) begin
         if (!rst_n)
            powered[i] <= 1'b0;
         else if (sel_we && wr_fn == FN_POWER && wr_slot == SLOT_NUM)
            powered[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/slot_status_mux.sv
module slot_status_mux
   import slot_ctl_pkg::*;
#(
   parameter int NUM_SLOTS = 9,
   parameter int DATA_W    = 32
) (
   input  logic [SLOT_W-1:0]    sel_slot,
   input  logic [FUNC_W-1:0]    sel_fn,
   input  logic [NUM_SLOTS-1:0] present,
   input  logic [NUM_SLOTS-1:0] powered,
   input  logic [SLOT_W-1:0]    sup_slot,
   input  logic                 eep_sel,
   input  logic                 eep_dout,
   output logic [DATA_W-1:0]    status,
   output logic                 fn_known
);
   logic card_in;
   logic pwr_flag;
   logic pgood;

   always_comb begin
      card_in  = 1'b0;
      pwr_flag = 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (sel_slot == SLOT_W'(i + 1)) begin
            card_in  = present[i];
            pwr_flag = powered[i];
         end
      end
   end

   assign pgood = pwr_flag || (sel_slot == sup_slot);

   always_comb begin
      status   = '0;
      fn_known = 1'b1;
      case (sel_fn)
         FN_PRESENCE: begin
            status[ST_EMPTY] = !card_in;
            status[ST_PGOOD] = card_in && pgood;
         end
         FN_EMPTY:  status[ST_EMPTY] = !card_in;
         FN_POWER:  status[ST_CONV]  = 1'b1;
         FN_EEPROM: status[0]        = eep_sel && eep_dout;
         default:   fn_known         = 1'b0;
      endcase
   end
endmodule

// File: rtl/slot_ctl_regs.sv
module slot_ctl_regs
   import slot_ctl_pkg::*;
#(
   parameter int NUM_SLOTS     = 9,
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32,
   parameter bit UNMAPPED_ONES = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rdata_o,
   output logic                 rvalid_o,
   input  logic [NUM_SLOTS-1:0] present_i,
   input  logic [SLOT_W-1:0]    sup_slot_i,
   input  logic                 eep_sel_i,
   input  logic                 eep_dout_i,
   output logic [NUM_SLOTS-1:0] powered_o,
   output logic [SLOT_W-1:0]    sel_slot_o,
   output logic                 func_err_o
);
   localparam int MAX_SLOTS = (1 << SLOT_W) - 1;

   if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS must fit the 4-bit slot field");
   end
   if (DATA_W < 16) begin : g_bad_data
      $error("DATA_W must hold the selector fields");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must reach every offset");
   end

   logic [DATA_W-1:0] unmapped_val;
   if (UNMAPPED_ONES) begin : g_ones
      assign unmapped_val = '1;
   end else begin : g_zero
      assign unmapped_val = '0;
   end

   logic [DATA_W-1:0] sel_word;
   logic [FUNC_W-1:0] sel_fn;
   logic [DATA_W-1:0] status;
   logic              fn_known;
   logic              sel_we;

   assign sel_we = wr_en && (wr_addr == ADDR_W'(OFF_SEL));

   slot_sel_reg #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_we   (sel_we),
      .wdata    (wdata),
      .sel_word (sel_word),
      .sel_slot (sel_slot_o),
      .sel_fn   (sel_fn),
      .powered  (powered_o)
   );

   slot_status_mux #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_stat (
      .sel_slot (sel_slot_o),
      .sel_fn   (sel_fn),
      .present  (present_i),
      .powered  (powered_o),
      .sup_slot (sup_slot_i),
      .eep_sel  (eep_sel_i),
      .eep_dout (eep_dout_i),
      .status   (status),
      .fn_known (fn_known)
   );

   logic [DATA_W-1:0] rd_val;
   always_comb begin
      case (rd_addr)
         ADDR_W'(OFF_ID):   rd_val = DATA_W'({sup_slot_i, ID_LOW});
         ADDR_W'(OFF_SEL):  rd_val = sel_word;
         ADDR_W'(OFF_STAT): rd_val = status;
         ADDR_W'(OFF_RSV0),
         ADDR_W'(OFF_RSV1),
         ADDR_W'(OFF_RSV2): rd_val = '0;
         ADDR_W'(OFF_MARK): rd_val = DATA_W'(MARK_VAL);
         default:           rd_val = unmapped_val;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_o    <= '0;
         rvalid_o   <= 1'b0;
         func_err_o <= 1'b0;
      end else begin
         rvalid_o <= rd_en;
         if (rd_en) rdata_o <= rd_val;
         if (rd_en && rd_addr == ADDR_W'(OFF_STAT) && !fn_known)
            func_err_o <= 1'b1;
      end
   end
endmodule

// File: rtl/slot_ctl_regs_chk.sv
module slot_ctl_regs_chk
   import slot_ctl_pkg::*;
#(
   parameter int NUM_SLOTS = 9,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [ADDR_W-1:0]    wr_addr,
   input logic [DATA_W-1:0]    wdata,
   input logic                 rd_en,
   input logic [ADDR_W-1:0]    rd_addr,
   input logic [DATA_W-1:0]    rdata_o,
   input logic                 rvalid_o,
   input logic [SLOT_W-1:0]    sup_slot_i,
   input logic [NUM_SLOTS-1:0] powered_o,
   input logic [SLOT_W-1:0]    sel_slot_o,
   input logic                 func_err_o
);
   logic pwr_write;
   assign pwr_write = wr_en && wr_addr == ADDR_W'(OFF_SEL) &&
                      wdata[FUNC_LSB +: FUNC_W] == FN_POWER;

   assert_sel_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(OFF_SEL)) |=> sel_slot_o == $past(wdata[SLOT_LSB +: SLOT_W]));

   assert_pwr_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((powered_o & $past(powered_o)) == $past(powered_o)));

   assert_pwr_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_write |=> $stable(powered_o));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      func_err_o |=> func_err_o);

   assert_id_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADDR_W'(OFF_ID)) |=> rdata_o == DATA_W'({$past(sup_slot_i), ID_LOW}));

   assert_mark_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADDR_W'(OFF_MARK)) |=> rdata_o == DATA_W'(MARK_VAL));

   assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rvalid_o);

   assert_rvalid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rvalid_o);
endmodule

bind slot_ctl_regs slot_ctl_regs_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wdata      (wdata),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .rdata_o    (rdata_o),
   .rvalid_o   (rvalid_o),
   .sup_slot_i (sup_slot_i),
   .powered_o  (powered_o),
   .sel_slot_o (sel_slot_o),
   .func_err_o (func_err_o)
);

// File: tb/slot_ctl_regs_tb.sv
module slot_ctl_regs_tb;
   localparam int NS = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata_o;
   logic        rvalid_o;
   logic [NS-1:0] present_i = 9'b1_0000_0101;
   logic [3:0]  sup_slot_i = 4'd1;
   logic        eep_sel_i = 1'b1, eep_dout_i = 1'b1;
   logic [NS-1:0] powered_o;
   logic [3:0]  sel_slot_o;
   logic        func_err_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   slot_ctl_regs #(.NUM_SLOTS(NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
      .rd_en(rd_en), .rd_addr(rd_addr), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
      .present_i(present_i), .sup_slot_i(sup_slot_i), .eep_sel_i(eep_sel_i),
      .eep_dout_i(eep_dout_i), .powered_o(powered_o), .sel_slot_o(sel_slot_o),
      .func_err_o(func_err_o)
   );

   typedef struct packed {
      logic        is_wr;
      logic [3:0]  req;
      logic [7:0]  addr;
      logic [31:0] data;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 4'd1,  8'h08, 32'h0000_3000},
      '{1'b0, 4'd3,  8'h0C, 32'h0000_0000}, // R3 present, unpowered
      '{1'b1, 4'd1,  8'h08, 32'h0000_1000},
      '{1'b0, 4'd4,  8'h0C, 32'h0000_0002}, // R4 supervisor slot
      '{1'b1, 4'd1,  8'h08, 32'h0000_2000},
      '{1'b0, 4'd3,  8'h0C, 32'h0000_0001}, // R3 empty
      '{1'b1, 4'd1,  8'h08, 32'h0000_3100},
      '{1'b0, 4'd5,  8'h0C, 32'h0000_0000}, // R5 present
      '{1'b1, 4'd1,  8'h08, 32'h0000_2100},
      '{1'b0, 4'd5,  8'h0C, 32'h0000_0001}, // R5 empty
      '{1'b1, 4'd2,  8'h08, 32'h0000_3200},
      '{1'b0, 4'd6,  8'h0C, 32'h0000_0008}, // R6 converter
      '{1'b1, 4'd1,  8'h08, 32'h0000_3000},
      '{1'b0, 4'd2,  8'h0C, 32'h0000_0002}, // R2 slot 3 now powered
      '{1'b1, 4'd1,  8'h08, 32'h0000_9500},
      '{1'b0, 4'd7,  8'h0C, 32'h0000_0001}, // R7 data-out bit
      '{1'b0, 4'd1,  8'h08, 32'h0000_9500}, // R1 readback
      '{1'b0, 4'd9,  8'h00, 32'h0000_0180}, // R9 identity
      '{1'b0, 4'd10, 8'h14, 32'h0000_0000}, // R10 reserved zero
      '{1'b0, 4'd10, 8'h1C, 32'h0000_8000}, // R10 marker
      '{1'b0, 4'd10, 8'h40, 32'hFFFF_FFFF}, // R10 unmapped
      '{1'b1, 4'd10, 8'h40, 32'h1234_5678},
      '{1'b0, 4'd10, 8'h08, 32'h0000_9500}  // R10 stray write ignored
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] v, output logic vld);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata_o; vld = rvalid_o;
   endtask

   task automatic both(input logic [31:0] wd, output logic [31:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h08; wdata = wd;
      rd_en = 1'b1; rd_addr = 8'h0C;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      v = rdata_o;
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic        vld;
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 rdata", rdata_o, 32'h0);
      check("R12 rvalid", {31'h0, rvalid_o}, 32'h0);
      check("R12 powered", {23'h0, powered_o}, 32'h0);
      check("R12 err", {31'h0, func_err_o}, 32'h0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         if (VEC[k].is_wr) bus_write(VEC[k].addr, VEC[k].data);
         else begin
            bus_read(VEC[k].addr, v, vld);
            check($sformatf("R%0d vector %0d", VEC[k].req, k), v, VEC[k].data);
         end
      end
      check("R2 powered after table", {23'h0, powered_o}, 32'h004);
      check("R1 sel_slot_o", {28'h0, sel_slot_o}, 32'd9);

      // R11 valid timing
      bus_read(8'h0C, v, vld);
      check("R11 rvalid high", {31'h0, vld}, 32'h1);
      @(negedge clk);
      check("R11 rvalid low", {31'h0, rvalid_o}, 32'h0);

      // R7 qualifier and zero data
      eep_sel_i = 1'b0;
      bus_read(8'h0C, v, vld);
      check("R7 not selected", v, 32'h0);
      eep_sel_i = 1'b1; eep_dout_i = 1'b0;
      bus_read(8'h0C, v, vld);
      check("R7 dout zero", v, 32'h0);

      // R8 unknown code
      bus_write(8'h08, 32'h0000_3700);
      bus_read(8'h0C, v, vld);
      check("R8 unknown code data", v, 32'h0);
      check("R8 err set", {31'h0, func_err_o}, 32'h1);
      bus_write(8'h08, 32'h0000_3000);
      bus_read(8'h0C, v, vld);
      check("R8 err sticky", {31'h0, func_err_o}, 32'h1);

      // R2 out-of-range and other codes
      bus_write(8'h08, 32'h0000_0200);
      bus_write(8'h08, 32'h0000_C200);
      bus_write(8'h08, 32'h0000_5300);
      check("R2 no stray power", {23'h0, powered_o}, 32'h004);
      bus_write(8'h08, 32'h0000_C000);
      bus_read(8'h0C, v, vld);
      check("R3 out-of-range empty", v, 32'h1);

      // R4 supervisor slot override
      sup_slot_i = 4'd9;
      bus_write(8'h08, 32'h0000_9000);
      bus_read(8'h0C, v, vld);
      check("R4 sup slot 9", v, 32'h2);
      bus_write(8'h08, 32'h0000_1000);
      bus_read(8'h0C, v, vld);
      check("R4 slot 1 no longer sup", v, 32'h0);
      bus_read(8'h00, v, vld);
      check("R9 id slot 9", v, 32'h0980);

      // R11 same-cycle write and read
      bus_write(8'h08, 32'h0000_3000);
      both(32'h0000_2000, v);
      check("R11 read sees old selector", v, 32'h2);
      bus_read(8'h0C, v, vld);
      check("R11 next read sees new", v, 32'h1);
      sup_slot_i = 4'd1;
      both(32'h0000_9000 | 32'h0200, v);
      check("R11 read before power write", v, 32'h1);
      check("R2 slot 9 powered", {23'h0, powered_o}, 32'h104);
      bus_write(8'h08, 32'h0000_9000);
      bus_read(8'h0C, v, vld);
      check("R11 power visible after", v, 32'h2);

      // R12 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R12 powered cleared", {23'h0, powered_o}, 32'h0);
      check("R12 err cleared", {31'h0, func_err_o}, 32'h0);
      check("R12 sel cleared", {28'h0, sel_slot_o}, 32'h0);
      rst_n = 1'b1;
      bus_read(8'h08, v, vld);
      check("R12 selector word zero", v, 32'h0);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule